// File: doc/BRIEF.md
# SDRAM Bank Open-Row and Precharge-Recovery Tracker

This block follows, for every bank of an SDRAM device, whether a row is currently open or the bank is idle, and whether the bank has finished its precharge recovery and may take a new command. A memory controller presents each decoded command with its bank-select bits, the A10 bit and the burst mode of the access. The block updates its per-bank view on the clock edge where the command is sampled. Commands that break the protocol are flagged and otherwise ignored.

Auto-precharge is chosen per read or write through A10. With a fixed-length burst, the addressed bank closes on its own when the burst ends. In full-page mode A10 is not honoured and the row stays open. Burst terminate, or a newer read or write, cuts the running burst short. If the cut burst carried auto-precharge, the bank closes at that edge. Recovery after every close, explicit or automatic, is timed by a counter loaded from a run-time input.

Top module: `sdram_bank_tracker`

## Requirements
- R1: During and right after reset every bank is idle (`bank_open` all 0), every bank is ready (`bank_ready` all 1) and `violation` is 0.
- R2: Activate (cmd code 1) to an idle, ready bank sets its `bank_open` bit after that edge. Any of the following raises a violation and changes nothing: an activate to a bank that is open or still recovering, or a single-bank precharge (code 4, A10=0) to a bank that is still recovering.
- R3: A read (code 2) or write (code 3) to an idle bank raises a violation and changes no bank state.
- R4: A read or write with A10=0 leaves the row open for as long as no precharge arrives.
- R5: A read or write with A10=1 and `full_page`=0 keeps the bank open, with `bank_ready` low, until the BURST_LEN-th clock edge after the command edge. At that edge the bank closes.
- R6: A read or write with `full_page`=1 ignores A10. No auto-precharge takes place, the bank stays open and `bank_ready` stays high, even after a burst terminate.
- R7: Precharge with A10=0 closes only the bank chosen by `cmd_bank`. The same command to an idle, ready bank has no effect and is legal.
- R8: Precharge with A10=1 closes every open bank, whatever `cmd_bank` holds.
- R9: After the edge that closes a bank, whether by explicit or automatic precharge, `bank_ready` for that bank stays low for exactly `trp_cycles` edges and rises on the next. With `trp_cycles`=0 the bank is ready at once.
- R10: Burst terminate (code 5) ends the running burst. If that burst carried auto-precharge, its bank closes at the terminate edge and recovery starts there.
- R11: A legal read or write ends the previous burst. A pending auto-precharge of the previous bank fires at that edge.
- R12: While a bank awaits auto-precharge, any of the following raises a violation and is ignored: a read, write, activate or single precharge to that bank, or a precharge-all.
- R13: `violation` is high for exactly the cycle after the edge of an illegal command, and low after legal ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 burst terminate |
| cmd_bank | input | 2 | Bank select of the command |
| cmd_a10 | input | 1 | Auto-precharge enable (read/write) or all-banks select (precharge) |
| full_page | input | 1 | Burst mode of a read/write: 1 selects full-page |
| trp_cycles | input | 4 | Precharge recovery time in clock cycles |
| bank_open | output | 4 | Per-bank open-row flag |
| bank_ready | output | 4 | Per-bank ready flag: no recovery running and no auto-precharge pending |
| violation | output | 1 | Registered flag for an illegal command |

## Verification
The main sweep crosses every bank, both reads and writes, and every recovery time from 0 to 3. Each auto-precharge burst is timed against the close edge and the ready edge predicted from BURST_LEN and `trp_cycles`, which separates off-by-one errors in the burst count from off-by-one errors in the recovery count. Further patterns cover these cases: a precharge of one bank against a precharge of all banks while all four are open, full-page bursts with A10 set, and bursts cut short by terminate or by a newer access. Each of these shows whether the close happens at the correct edge and on the correct bank only. Illegal sequences check that the flag rises and that state is left untouched. They include commands to idle banks, to recovering banks and to banks awaiting auto-precharge.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5
  } cmd_e;
endpackage

// File: rtl/bank_slot.sv
// One bank: open-row flag and precharge recovery down-counter.
module bank_slot #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          close_i,
  input  logic [TW-1:0] trp_i,
  output logic          open_o,
  output logic          rc_zero_o
);
  logic          open_q, open_d;
  logic [TW-1:0] rc_q, rc_d;
  logic          rc_en;

  always_comb begin
    open_d = open_q;
    rc_d   = rc_q;
    rc_en  = 1'b0;
    if (close_i) begin
      open_d = 1'b0;
      rc_d   = trp_i;
      rc_en  = 1'b1;
    end else if (act_i) begin
      open_d = 1'b1;
    end else if (rc_q != '0) begin
      rc_d  = rc_q - 1'b1;
      rc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rc_q   <= '0;
    end else begin
      open_q <= open_d;
      if (rc_en) rc_q <= rc_d;
    end
  end

  assign open_o    = open_q;
  assign rc_zero_o = (rc_q == '0);
endmodule

// File: rtl/burst_engine.sv
// Tracks the most recent read/write burst and fires its auto-precharge.
module burst_engine #(
  parameter int NB        = 4,
  parameter int BURST_LEN = 4,
  localparam int BW = $clog2(NB),
  localparam int RW = $clog2(BURST_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [BW-1:0] start_bank_i,
  input  logic          start_ap_i,
  input  logic          start_full_i,
  input  logic          term_i,
  output logic [NB-1:0] ap_pend_o,
  output logic [NB-1:0] ap_close_o
);
  logic          act_q, act_d;
  logic          ap_q, ap_d;
  logic          full_q, full_d;
  logic [BW-1:0] bank_q, bank_d;
  logic [RW-1:0] rem_q, rem_d;
  logic          end_now;
  logic [NB-1:0] bank_sel;

  assign bank_sel = {{(NB-1){1'b0}}, 1'b1} << bank_q;
  assign end_now  = act_q && (start_i || term_i || (!full_q && rem_q == RW'(1)));

  always_comb begin
    act_d  = act_q;
    ap_d   = ap_q;
    full_d = full_q;
    bank_d = bank_q;
    rem_d  = rem_q;
    if (start_i) begin
      act_d  = 1'b1;
      ap_d   = start_ap_i;
      full_d = start_full_i;
      bank_d = start_bank_i;
      rem_d  = RW'(BURST_LEN);
    end else if (end_now) begin
      act_d = 1'b0;
      ap_d  = 1'b0;
    end else if (act_q && !full_q) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ap_q   <= 1'b0;
      full_q <= 1'b0;
      bank_q <= '0;
      rem_q  <= '0;
    end else begin
      act_q  <= act_d;
      ap_q   <= ap_d;
      full_q <= full_d;
      bank_q <= bank_d;
      rem_q  <= rem_d;
    end
  end

  assign ap_pend_o  = (act_q && ap_q) ? bank_sel : '0;
  assign ap_close_o = (end_now && ap_q) ? bank_sel : '0;
endmodule

// File: rtl/cmd_check.sv
// Legality decode of one command against the current bank view.
module cmd_check
  import bank_trk_pkg::*;
#(
  parameter int NB = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic [2:0]    cmd_i,
  input  logic [BW-1:0] bank_i,
  input  logic          a10_i,
  input  logic          full_i,
  input  logic [NB-1:0] open_i,
  input  logic [NB-1:0] rc_zero_i,
  input  logic [NB-1:0] ap_pend_i,
  output logic          viol_o,
  output logic [NB-1:0] act_hit_o,
  output logic [NB-1:0] pre_hit_o,
  output logic          burst_start_o,
  output logic          burst_ap_o,
  output logic          term_o
);
  cmd_e          op;
  logic [NB-1:0] sel;
  logic          recovering;
  logic          is_rw;

  assign op         = cmd_e'(cmd_i);
  assign sel        = {{(NB-1){1'b0}}, 1'b1} << bank_i;
  assign recovering = !rc_zero_i[bank_i];
  assign is_rw      = (op == CMD_RD) || (op == CMD_WR);

  always_comb begin
    viol_o = 1'b0;
    unique case (op)
      CMD_ACT: viol_o = open_i[bank_i] || recovering || ap_pend_i[bank_i];
      CMD_RD,
      CMD_WR:  viol_o = !open_i[bank_i] || ap_pend_i[bank_i];
      CMD_PRE: viol_o = a10_i ? (|ap_pend_i) : (recovering || ap_pend_i[bank_i]);
      default: viol_o = 1'b0;
    endcase
  end

  always_comb begin
    act_hit_o = '0;
    pre_hit_o = '0;
    if (!viol_o) begin
      if (op == CMD_ACT) act_hit_o = sel;
      if (op == CMD_PRE) pre_hit_o = a10_i ? open_i : (sel & open_i);
    end
  end

  assign burst_start_o = is_rw && !viol_o;
  assign burst_ap_o    = a10_i && !full_i;
  assign term_o        = (op == CMD_BST);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int NB        = 4,
  parameter int BURST_LEN = 4,
  parameter int TW        = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd,
  input  logic [BW-1:0] cmd_bank,
  input  logic          cmd_a10,
  input  logic          full_page,
  input  logic [TW-1:0] trp_cycles,
  output logic [NB-1:0] bank_open,
  output logic [NB-1:0] bank_ready,
  output logic          violation
);
  logic [NB-1:0] rc_zero;
  logic [NB-1:0] ap_pend;
  logic [NB-1:0] ap_close;
  logic [NB-1:0] act_hit;
  logic [NB-1:0] pre_hit;
  logic          cmd_viol;
  logic          burst_start;
  logic          burst_ap;
  logic          term;
  logic          viol_q;

  cmd_check #(.NB(NB)) u_check (
    .cmd_i        (cmd),
    .bank_i       (cmd_bank),
    .a10_i        (cmd_a10),
    .full_i       (full_page),
    .open_i       (bank_open),
    .rc_zero_i    (rc_zero),
    .ap_pend_i    (ap_pend),
    .viol_o       (cmd_viol),
    .act_hit_o    (act_hit),
    .pre_hit_o    (pre_hit),
    .burst_start_o(burst_start),
    .burst_ap_o   (burst_ap),
    .term_o       (term)
  );

  burst_engine #(.NB(NB), .BURST_LEN(BURST_LEN)) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (burst_start),
    .start_bank_i(cmd_bank),
    .start_ap_i  (burst_ap),
    .start_full_i(full_page),
    .term_i      (term),
    .ap_pend_o   (ap_pend),
    .ap_close_o  (ap_close)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    bank_slot #(.TW(TW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (act_hit[g]),
      .close_i  (pre_hit[g] | ap_close[g]),
      .trp_i    (trp_cycles),
      .open_o   (bank_open[g]),
      .rc_zero_o(rc_zero[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= cmd_viol;
  end

  assign violation  = viol_q;
  assign bank_ready = rc_zero & ~ap_pend;
endmodule

// File: rtl/bank_trk_chk.sv
module bank_trk_chk #(
  parameter int NB = 4,
  parameter int TW = 4,
  localparam int BW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cmd,
  input logic [BW-1:0] cmd_bank,
  input logic          cmd_a10,
  input logic          full_page,
  input logic [TW-1:0] trp_cycles,
  input logic [NB-1:0] bank_open,
  input logic [NB-1:0] bank_ready,
  input logic          violation,
  input logic          cmd_viol
);
  // R2
  act_open_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1 && bank_open[cmd_bank]) |=> violation);

  // R3
  rw_idle_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == 3'd2 || cmd == 3'd3) && !bank_open[cmd_bank]) |=> violation);

  // R8
  pre_all_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd4 && cmd_a10 && !cmd_viol) |=> (bank_open == '0));

  // R6
  full_page_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == 3'd2 || cmd == 3'd3) && full_page && !cmd_viol)
      |=> bank_open[$past(cmd_bank)]);

  for (genvar i = 0; i < NB; i++) begin : g_rdy
    // R9
    rdy_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bank_open[i]) && $past(trp_cycles) != '0) |-> !bank_ready[i]);
  end
endmodule

bind sdram_bank_tracker bank_trk_chk #(.NB(NB), .TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd       (cmd),
  .cmd_bank  (cmd_bank),
  .cmd_a10   (cmd_a10),
  .full_page (full_page),
  .trp_cycles(trp_cycles),
  .bank_open (bank_open),
  .bank_ready(bank_ready),
  .violation (violation),
  .cmd_viol  (cmd_viol)
);

// File: tb/sim_sdram_bank_tracker.sv
`timescale 1ns/1ps
module sim_sdram_bank_tracker;
  localparam int BL = 4;

  logic       clk;
  logic       rst_n;
  logic [2:0] cmd;
  logic [1:0] cmd_bank;
  logic       cmd_a10;
  logic       full_page;
  logic [3:0] trp_cycles;
  logic [3:0] bank_open;
  logic [3:0] bank_ready;
  logic       violation;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  sdram_bank_tracker #(.NB(4), .BURST_LEN(BL), .TW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_a10(cmd_a10), .full_page(full_page), .trp_cycles(trp_cycles),
    .bank_open(bank_open), .bank_ready(bank_ready), .violation(violation)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic a, input logic fp);
    cmd = c; cmd_bank = b; cmd_a10 = a; full_page = fp;
    @(negedge clk);
    cmd = 3'd0; cmd_a10 = 1'b0; full_page = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cmd = 3'd0; cmd_bank = 2'd0; cmd_a10 = 1'b0; full_page = 1'b0; trp_cycles = 4'd2;
    rst_n = 1'b0;
    idle(3);
    chk("R1 open", 32'(bank_open), 32'h0);
    chk("R1 ready", 32'(bank_ready), 32'hF);
    chk("R1 viol", 32'(violation), 32'h0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 open after release", 32'(bank_open), 32'h0);

    // Sweep: recovery times x banks x read/write with auto-precharge
    for (int t = 0; t < 4; t++) begin
      for (int b = 0; b < 4; b++) begin
        for (int w = 0; w < 2; w++) begin
          trp_cycles = 4'(t);
          issue(3'd1, 2'(b), 1'b0, 1'b0);
          chk("R2 act opens", 32'(bank_open), 32'(1 << b));
          chk("R13 legal act", 32'(violation), 32'h0);
          issue(3'd1, 2'(b), 1'b0, 1'b0);
          chk("R2 act open bank viol", 32'(violation), 32'h1);
          chk("R2 act open bank state", 32'(bank_open), 32'(1 << b));
          issue(w ? 3'd3 : 3'd2, 2'(b), 1'b1, 1'b0);
          chk("R5 open during burst", 32'(bank_open), 32'(1 << b));
          chk("R5 not ready during burst", 32'(bank_ready[b]), 32'h0);
          chk("R13 legal rw", 32'(violation), 32'h0);
          for (int i = 1; i < BL; i++) begin
            idle(1);
            chk("R5 still open", 32'(bank_open[b]), 32'h1);
          end
          idle(1);
          chk("R5 closed at burst end", 32'(bank_open), 32'h0);
          chk("R9 ready at close", 32'(bank_ready[b]), 32'(t == 0));
          for (int m = 1; m <= t; m++) begin
            if (m == 1 && t >= 2) begin
              issue(3'd1, 2'(b), 1'b0, 1'b0);
              chk("R2 act in recovery viol", 32'(violation), 32'h1);
              chk("R2 act in recovery ignored", 32'(bank_open), 32'h0);
            end else begin
              idle(1);
            end
            chk("R9 ready count", 32'(bank_ready[b]), 32'(m >= t));
          end
        end
      end
    end

    // R3: read to idle bank
    issue(3'd2, 2'd1, 1'b0, 1'b0);
    chk("R3 rd idle viol", 32'(violation), 32'h1);
    chk("R3 rd idle state", 32'(bank_open), 32'h0);
    idle(1);
    chk("R13 viol one cycle", 32'(violation), 32'h0);

    // R4, R7, R8
    trp_cycles = 4'd2;
    for (int b = 0; b < 4; b++) issue(3'd1, 2'(b), 1'b0, 1'b0);
    issue(3'd2, 2'd0, 1'b0, 1'b0);
    idle(BL + 3);
    chk("R4 row stays open", 32'(bank_open), 32'hF);
    issue(3'd4, 2'd2, 1'b0, 1'b0);
    chk("R7 single close", 32'(bank_open), 32'hB);
    chk("R7 ready pattern", 32'(bank_ready), 32'hB);
    issue(3'd4, 2'd2, 1'b0, 1'b0);
    chk("R2 pre in recovery viol", 32'(violation), 32'h1);
    idle(1);
    chk("R9 ready after trp", 32'(bank_ready), 32'hF);
    issue(3'd4, 2'd2, 1'b0, 1'b0);
    chk("R7 pre idle no viol", 32'(violation), 32'h0);
    chk("R7 pre idle no effect", 32'(bank_open), 32'hB);
    chk("R7 pre idle ready", 32'(bank_ready), 32'hF);
    issue(3'd4, 2'd2, 1'b1, 1'b0);
    chk("R8 all closed", 32'(bank_open), 32'h0);
    chk("R8 ready pattern", 32'(bank_ready), 32'h4);
    idle(2);
    chk("R9 all ready", 32'(bank_ready), 32'hF);

    // R6: full-page
    trp_cycles = 4'd1;
    issue(3'd1, 2'd3, 1'b0, 1'b0);
    issue(3'd2, 2'd3, 1'b1, 1'b1);
    idle(BL + 4);
    chk("R6 full page open", 32'(bank_open), 32'h8);
    chk("R6 full page ready", 32'(bank_ready), 32'hF);
    issue(3'd5, 2'd0, 1'b0, 1'b0);
    chk("R6 terminate keeps open", 32'(bank_open), 32'h8);
    issue(3'd4, 2'd3, 1'b0, 1'b0);
    idle(1);

    // R10: terminate cuts auto-precharge burst
    issue(3'd1, 2'd0, 1'b0, 1'b0);
    issue(3'd3, 2'd0, 1'b1, 1'b0);
    idle(1);
    chk("R10 open before terminate", 32'(bank_open), 32'h1);
    issue(3'd5, 2'd1, 1'b0, 1'b0);
    chk("R10 closed at terminate", 32'(bank_open), 32'h0);
    chk("R10 recovery started", 32'(bank_ready[0]), 32'h0);
    idle(1);
    chk("R10 ready after trp", 32'(bank_ready[0]), 32'h1);

    // R11: newer access ends pending auto-precharge burst
    issue(3'd1, 2'd1, 1'b0, 1'b0);
    issue(3'd1, 2'd2, 1'b0, 1'b0);
    issue(3'd2, 2'd1, 1'b1, 1'b0);
    issue(3'd2, 2'd2, 1'b0, 1'b0);
    chk("R11 old bank closed", 32'(bank_open), 32'h4);
    chk("R11 no viol", 32'(violation), 32'h0);
    issue(3'd4, 2'd2, 1'b0, 1'b0);
    idle(2);

    // R12: commands against pending auto-precharge
    issue(3'd1, 2'd0, 1'b0, 1'b0);
    issue(3'd2, 2'd0, 1'b1, 1'b0);
    issue(3'd3, 2'd0, 1'b0, 1'b0);
    chk("R12 wr pending viol", 32'(violation), 32'h1);
    issue(3'd4, 2'd1, 1'b1, 1'b0);
    chk("R12 pre all pending viol", 32'(violation), 32'h1);
    chk("R12 still open", 32'(bank_open), 32'h1);
    issue(3'd1, 2'd0, 1'b0, 1'b0);
    chk("R12 act pending viol", 32'(violation), 32'h1);
    idle(1);
    chk("R12 auto close on time", 32'(bank_open), 32'h0);
    chk("R13 viol cleared", 32'(violation), 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule